// File: doc/BRIEF.md
# Clock-Selectable Prescaled Timer

This block is a general-purpose up/down counter whose count pulses come from one of two places. In the default mode, a programmable prescaler divides the free-running system clock. In external clock mode, the timer counts rising edges of one trigger picked from seven synchronous sources, and those edges also pass through the prescaler.

The counter can run one-way, either up or down, or two-way, where it climbs to the period value and falls back to zero. Each time it wraps or turns, it emits a one-cycle overflow pulse and sets a sticky flag. Software clears the flag with a write-one-to-clear strobe.

The divider and period inputs are shadowed. While the timer is stopped, the active copies track the inputs. While it runs, new values take effect only at an overflow, so a period in progress is never cut short.

Top module: `clocksel_timer`

## Requirements
- R1: During reset and on the first cycle after it, `count` is 0, `ovfEvent` is 0 and `ovfFlag` is 0, and the two-way direction state is upward.
- R2: While `enable` is 0, `count`, the prescaler and the flag state hold. No overflow occurs, and the active divider and period copy `divIn` and `periodIn` on every cycle.
- R3: In internal clock mode with `enable` at 1, the counter takes one step every `divAct`+1 clock cycles. The first step lands on the (`divAct`+1)-th rising clock edge after enabling.
- R4: In one-way mode (`countMode` = 2'b00) with `dirDown` = 0, the count rises to the active period. The next step goes to 0 and is an overflow.
- R5: In one-way mode with `dirDown` = 1, the count falls by one per step. A step taken at 0 reloads the active period and is an overflow.
- R6: With `countMode` not 2'b00, the count rises to the active period, then falls to 0, then rises again. The step leaving the period value and the step leaving 0 are both overflows.
- R7: With `slaveMode` = 3'b111, a step source event is a 0-to-1 change of the selected trigger between two consecutive clock samples. These events feed the same prescaler.
- R8: `trigSel` codes 0 to 3 select `intTrig[0]` to `intTrig[3]`. Code 4 selects `ch1Edge`, code 5 selects `ch1Filt`, code 6 selects `ch2Filt`, and code 7 selects a constant 0.
- R9: Every `slaveMode` value other than 3'b111 behaves as internal clock mode, and trigger activity is then ignored.
- R10: While running, changes to `divIn` and `periodIn` take effect only at the next overflow.
- R11: `ovfEvent` is high for exactly the one cycle after an overflow step, in the same cycle that `count` shows the wrapped value.
- R12: `ovfFlag` sets together with `ovfEvent` and stays set until a cycle with `ovfClr` at 1 and no new overflow. A new overflow wins over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal count source |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run control; 0 freezes the timer |
| countMode | input | 2 | 2'b00 one-way, any other value two-way |
| dirDown | input | 1 | One-way direction: 0 up, 1 down |
| slaveMode | input | 3 | 3'b111 external trigger clock, others internal clock |
| trigSel | input | 3 | Trigger source select (see R8) |
| intTrig | input | 4 | Internal trigger sources |
| ch1Edge | input | 1 | Channel 1 edge signal |
| ch1Filt | input | 1 | Filtered channel 1 |
| ch2Filt | input | 1 | Filtered channel 2 |
| divIn | input | DIV_W | Prescaler value, divides by divIn+1 |
| periodIn | input | CNT_W | Period (wrap value) |
| ovfClr | input | 1 | Write-one-to-clear for the overflow flag |
| count | output | CNT_W | Current counter value |
| ovfEvent | output | 1 | One-cycle overflow pulse |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
The counting path is driven from both sources. Plain clock cycles are run at several divider values, so the step rate can be told apart from the period. Trigger square waves are sent through three different selects. Up, down and two-way runs are each stopped just before and just after a wrap or turning point, which separates a correct wrap value from an off-by-one. Other patterns check the remaining behaviour:
- A toggling trigger under a non-external mode code, or on an unselected source, must leave the count at the plain clock rate or at zero.
- A mid-run change of divider and period must show the old values up to the overflow and the new ones after it.

// File: rtl/timer_pkg.sv
`timescale 1ns/1ps
package timer_pkg;
  localparam logic [2:0] SLAVE_EXTCLK = 3'b111;
  localparam logic [1:0] MODE_ONEWAY  = 2'b00;

  typedef struct packed {
    logic tick;     // one counter step this cycle
    logic oneWay;   // one-way counting selected
    logic down;     // one-way direction is down
    logic clrFlag;  // clear request for the sticky flag
  } tmrStrobe_t;
endpackage

// File: rtl/timer_ctrl.sv
`timescale 1ns/1ps
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       countMode,
  input  logic             dirDown,
  input  logic [2:0]       slaveMode,
  input  logic [2:0]       trigSel,
  input  logic [3:0]       intTrig,
  input  logic             ch1Edge,
  input  logic             ch1Filt,
  input  logic             ch2Filt,
  input  logic [DIV_W-1:0] divIn,
  input  logic [CNT_W-1:0] periodIn,
  input  logic             ovfClr,
  input  logic             wrapNow,
  output tmrStrobe_t       strb,
  output logic [CNT_W-1:0] periodAct
);
  logic             trigSrc;
  logic             trigPrev;
  logic             srcEvent;
  logic             extMode;
  logic             prescDone;
  logic [DIV_W-1:0] prescCnt;
  logic [DIV_W-1:0] divAct;

  // trigger source multiplexer
  always_comb begin
    unique case (trigSel)
      3'd0:    trigSrc = intTrig[0];
      3'd1:    trigSrc = intTrig[1];
      3'd2:    trigSrc = intTrig[2];
      3'd3:    trigSrc = intTrig[3];
      3'd4:    trigSrc = ch1Edge;
      3'd5:    trigSrc = ch1Filt;
      3'd6:    trigSrc = ch2Filt;
      default: trigSrc = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) trigPrev <= 1'b0;
    else       trigPrev <= trigSrc;
  end

  assign extMode   = (slaveMode == SLAVE_EXTCLK);
  assign srcEvent  = extMode ? (trigSrc & ~trigPrev) : 1'b1;
  assign prescDone = (prescCnt >= divAct);

  // prescaler: counts source events, restarts on each output tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescCnt <= '0;
    end else if (enable && srcEvent) begin
      if (prescDone) prescCnt <= '0;
      else           prescCnt <= prescCnt + DIV_W'(1);
    end
  end

  // shadow copies: track inputs when stopped, reload at overflow when running
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divAct    <= '0;
      periodAct <= '0;
    end else if (!enable || wrapNow) begin
      divAct    <= divIn;
      periodAct <= periodIn;
    end
  end

  always_comb begin
    strb.tick    = enable && srcEvent && prescDone;
    strb.oneWay  = (countMode == MODE_ONEWAY);
    strb.down    = dirDown;
    strb.clrFlag = ovfClr;
  end
endmodule

// File: rtl/timer_dp.sv
`timescale 1ns/1ps
module timer_dp
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic [CNT_W-1:0] periodAct,
  output logic [CNT_W-1:0] count,
  output logic             wrapNow,
  output logic             ovfEvent,
  output logic             ovfFlag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             goingDown;
  logic             nextDown;
  logic [CNT_W-1:0] nextCnt;

  always_comb begin
    nextCnt  = count;
    nextDown = goingDown;
    wrapNow  = 1'b0;
    if (strb.tick) begin
      if (strb.oneWay) begin
        if (strb.down) begin
          if (count == '0 || count > periodAct) begin
            nextCnt = periodAct;
            wrapNow = 1'b1;
          end else begin
            nextCnt = count - ONE;
          end
        end else begin
          if (count >= periodAct) begin
            nextCnt = '0;
            wrapNow = 1'b1;
          end else begin
            nextCnt = count + ONE;
          end
        end
      end else if (goingDown) begin
        if (count == '0) begin
          nextCnt  = (periodAct == '0) ? '0 : ONE;
          nextDown = 1'b0;
          wrapNow  = 1'b1;
        end else begin
          nextCnt = count - ONE;
        end
      end else begin
        if (count >= periodAct) begin
          nextCnt  = (periodAct == '0) ? '0 : periodAct - ONE;
          nextDown = 1'b1;
          wrapNow  = 1'b1;
        end else begin
          nextCnt = count + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      goingDown <= 1'b0;
      ovfEvent  <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      count     <= nextCnt;
      goingDown <= nextDown;
      ovfEvent  <= wrapNow;
      if (wrapNow)           ovfFlag <= 1'b1;
      else if (strb.clrFlag) ovfFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/clocksel_timer.sv
`timescale 1ns/1ps
module clocksel_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [1:0]       countMode,
  input  logic             dirDown,
  input  logic [2:0]       slaveMode,
  input  logic [2:0]       trigSel,
  input  logic [3:0]       intTrig,
  input  logic             ch1Edge,
  input  logic             ch1Filt,
  input  logic             ch2Filt,
  input  logic [DIV_W-1:0] divIn,
  input  logic [CNT_W-1:0] periodIn,
  input  logic             ovfClr,
  output logic [CNT_W-1:0] count,
  output logic             ovfEvent,
  output logic             ovfFlag
);
  tmrStrobe_t       strb;
  logic [CNT_W-1:0] periodAct;
  logic             wrapNow;

  timer_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .countMode(countMode),
    .dirDown(dirDown), .slaveMode(slaveMode), .trigSel(trigSel),
    .intTrig(intTrig), .ch1Edge(ch1Edge), .ch1Filt(ch1Filt),
    .ch2Filt(ch2Filt), .divIn(divIn), .periodIn(periodIn),
    .ovfClr(ovfClr), .wrapNow(wrapNow), .strb(strb), .periodAct(periodAct)
  );

  timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .periodAct(periodAct),
    .count(count), .wrapNow(wrapNow), .ovfEvent(ovfEvent), .ovfFlag(ovfFlag)
  );
endmodule

// File: rtl/timer_chk.sv
`timescale 1ns/1ps
module timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic [1:0]       countMode,
  input logic             dirDown,
  input logic             ovfClr,
  input logic [CNT_W-1:0] count,
  input logic             ovfEvent,
  input logic             ovfFlag
);
  // R2
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(count));
  // R2
  frozen_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !ovfEvent);
  // R4
  up_wrap_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvent && $past(countMode) == 2'b00 && !$past(dirDown)) |-> (count == '0));
  // R11
  event_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvent |-> ovfFlag);
  // R12
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);
  // R12
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfClr |=> (ovfFlag == ovfEvent));
endmodule

bind clocksel_timer timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .countMode(countMode),
  .dirDown(dirDown), .ovfClr(ovfClr), .count(count),
  .ovfEvent(ovfEvent), .ovfFlag(ovfFlag)
);

// File: tb/clocksel_timer_test.sv
`timescale 1ns/1ps
module clocksel_timer_test;
  localparam int CNT_W = 16;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rstN;
  logic             enable;
  logic [1:0]       countMode;
  logic             dirDown;
  logic [2:0]       slaveMode;
  logic [2:0]       trigSel;
  logic [3:0]       intTrig;
  logic             ch1Edge, ch1Filt, ch2Filt;
  logic [DIV_W-1:0] divIn;
  logic [CNT_W-1:0] periodIn;
  logic             ovfClr;
  logic [CNT_W-1:0] count;
  logic             ovfEvent, ovfFlag;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;

  clocksel_timer #(.CNT_W(CNT_W), .DIV_W(DIV_W)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .countMode(countMode),
    .dirDown(dirDown), .slaveMode(slaveMode), .trigSel(trigSel),
    .intTrig(intTrig), .ch1Edge(ch1Edge), .ch1Filt(ch1Filt),
    .ch2Filt(ch2Filt), .divIn(divIn), .periodIn(periodIn), .ovfClr(ovfClr),
    .count(count), .ovfEvent(ovfEvent), .ovfFlag(ovfFlag)
  );

  typedef struct packed {
    logic [2:0]  sm;   // slaveMode
    logic [2:0]  ts;   // toggled source / trigSel
    logic [1:0]  cm;   // countMode
    logic        dn;   // dirDown
    logic [7:0]  dv;   // divider
    logic [7:0]  pr;   // period
    logic [7:0]  n;    // enabled cycles
    logic [15:0] cnt;  // expected count
    logic        fl;   // expected flag
  } vec_t;

  localparam vec_t VECS [14] = '{
    '{3'd0, 3'd0, 2'd0, 1'b0, 8'd0, 8'd22, 8'd22, 16'd22, 1'b0}, // R3 R4 before wrap
    '{3'd0, 3'd0, 2'd0, 1'b0, 8'd0, 8'd22, 8'd23, 16'd0,  1'b1}, // R4 wrap
    '{3'd0, 3'd0, 2'd0, 1'b0, 8'd2, 8'd10, 8'd20, 16'd6,  1'b0}, // R3 div 3
    '{3'd0, 3'd0, 2'd0, 1'b0, 8'd1, 8'd4,  8'd13, 16'd1,  1'b1}, // R3 R4
    '{3'd0, 3'd0, 2'd0, 1'b1, 8'd0, 8'd5,  8'd1,  16'd5,  1'b1}, // R5 reload
    '{3'd0, 3'd0, 2'd0, 1'b1, 8'd0, 8'd5,  8'd4,  16'd2,  1'b1}, // R5
    '{3'd0, 3'd0, 2'd1, 1'b0, 8'd0, 8'd4,  8'd6,  16'd2,  1'b1}, // R6 falling
    '{3'd0, 3'd0, 2'd2, 1'b0, 8'd0, 8'd4,  8'd4,  16'd4,  1'b0}, // R6 at top
    '{3'd0, 3'd0, 2'd3, 1'b0, 8'd0, 8'd4,  8'd9,  16'd1,  1'b1}, // R6 rising again
    '{3'd7, 3'd0, 2'd0, 1'b0, 8'd0, 8'd9,  8'd10, 16'd5,  1'b0}, // R7 R8 intTrig0
    '{3'd7, 3'd5, 2'd0, 1'b0, 8'd1, 8'd9,  8'd12, 16'd3,  1'b0}, // R7 R8 ch1Filt
    '{3'd7, 3'd6, 2'd0, 1'b0, 8'd0, 8'd2,  8'd8,  16'd1,  1'b1}, // R7 R8 ch2Filt
    '{3'd2, 3'd0, 2'd0, 1'b0, 8'd0, 8'd9,  8'd7,  16'd7,  1'b0}, // R9 other mode
    '{3'd7, 3'd7, 2'd0, 1'b0, 8'd0, 8'd9,  8'd10, 16'd0,  1'b0}  // R8 code 7
  };

  task automatic check(input string req, input longint act, input longint exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic driveSrc(input logic [2:0] sel, input logic v);
    intTrig = '0; ch1Edge = 1'b0; ch1Filt = 1'b0; ch2Filt = 1'b0;
    case (sel)
      3'd0, 3'd7: intTrig[0] = v;  // code 7 toggles an unselected source
      3'd1: intTrig[1] = v;
      3'd2: intTrig[2] = v;
      3'd3: intTrig[3] = v;
      3'd4: ch1Edge = v;
      3'd5: ch1Filt = v;
      default: ch2Filt = v;
    endcase
  endtask

  task automatic steps(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; enable = 1'b0; countMode = 2'b00; dirDown = 1'b0;
    slaveMode = 3'd0; trigSel = 3'd0; intTrig = '0; ch1Edge = 1'b0;
    ch1Filt = 1'b0; ch2Filt = 1'b0; divIn = '0; periodIn = '0; ovfClr = 1'b0;
    steps(2);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 count", count, 0);
    check("R1 event", ovfEvent, 0);
    check("R1 flag", ovfFlag, 0);

    // vector table
    for (int v = 0; v < 14; v++) begin
      doReset();
      slaveMode = VECS[v].sm; trigSel = VECS[v].ts; countMode = VECS[v].cm;
      dirDown = VECS[v].dn; divIn = DIV_W'(VECS[v].dv); periodIn = CNT_W'(VECS[v].pr);
      steps(1);
      enable = 1'b1;
      for (int i = 0; i < int'(VECS[v].n); i++) begin
        driveSrc(VECS[v].ts, 1'(i % 2));
        @(posedge clk);
        @(negedge clk);
      end
      check($sformatf("vector %0d count (R3-group)", v), count, VECS[v].cnt);
      check($sformatf("vector %0d flag (R12)", v), ovfFlag, VECS[v].fl);
    end

    // R2: not enabled -> no counting
    doReset();
    periodIn = 16'd20;
    steps(5);
    check("R2 disabled count", count, 0);

    // R2: freeze and resume
    enable = 1'b1; steps(3);
    check("R2 run before freeze", count, 3);
    enable = 1'b0; steps(4);
    check("R2 frozen count", count, 3);
    enable = 1'b1; steps(2);
    check("R2 resumed count", count, 5);

    // R10: preload takes effect at overflow
    doReset();
    periodIn = 16'd3; steps(1);
    enable = 1'b1; steps(2);
    divIn = 16'd1; periodIn = 16'd7;
    steps(2);
    check("R10 old period wrap", count, 0);
    steps(4);
    check("R10 new divider", count, 2);
    steps(8);
    check("R10 new period", count, 6);

    // R11 / R12: event pulse, sticky flag, clear
    doReset();
    periodIn = 16'd2; steps(1);
    enable = 1'b1; steps(3);
    check("R11 event on wrap", ovfEvent, 1);
    check("R11 count on wrap", count, 0);
    steps(1);
    check("R11 event one cycle", ovfEvent, 0);
    check("R12 flag sticky", ovfFlag, 1);
    ovfClr = 1'b1; steps(1); ovfClr = 1'b0;
    check("R12 flag cleared", ovfFlag, 0);
    steps(1);
    check("R12 flag set again", ovfFlag, 1);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule